// File: doc/BRIEF.md
# Banked SPI Register Command Engine

This block is an SPI slave (mode 0: SCK idles low, MOSI is sampled on the rising edge and MISO changes on the falling edge). It runs a byte-oriented command set against a banked file of 8-bit control registers and a byte buffer. The SPI pins are oversampled by the system clock through a short synchronizer. Each chip-select window carries one command. Its first byte is a header: the opcode sits in bits 7:5 and the register address in bits 4:0. The bytes after the header carry data in either direction, MSB first.

The register file has four banks of 32 addresses. Address 0x1F is a common control register that is reachable from every bank, and its two low bits select the active bank. Registers in the upper two banks at addresses 0x00 to 0x0F are slow-path registers: a read of one of them sends a dummy byte before the data. The buffer is reached through one pointer. The pointer advances by one for each streamed byte and wraps at the end of the buffer.

Top module: `spi_bank_engine`

## Requirements
- R1: The header is the first byte after CS_n falls, with opcode = bits 7:5 and address = bits 4:0. MISO is 0 during the header byte and whenever CS_n is high. Data is shifted MSB first in SPI mode 0.
- R2: Opcode 010 (register write) stores the second byte into the addressed register of the active bank. Any bytes after the second one in the same window are ignored.
- R3: Opcode 000 (register read) of an ordinary register returns its value on MISO during byte 2. Every later byte of the window returns 0x00.
- R4: A read of a slow-path register (bank 2 or 3, address 0x00 to 0x0F) returns 0x00 during byte 2 and the value during byte 3. Later bytes return 0x00.
- R5: Opcode 100 ORs the data byte into the addressed register, and opcode 101 clears the register bits that are set in the data byte. Both use exactly one data byte.
- R6: Address 0x1F is the same 8-bit register in every bank. Its bits 1:0 give the active bank number. It changes only through opcodes 010, 100 and 101.
- R7: A header of exactly 0x7A (buffer write) stores every following byte of the window at the pointer and then advances the pointer by 1. The pointer wraps from 63 to 0.
- R8: A header of exactly 0x3A (buffer read) returns the buffer byte at the pointer during each following byte of the window. The pointer advances by 1 per returned byte, with the same wrap.
- R9: Opcode 110, opcode 001 or 011 with any header other than 0x3A or 0x7A, and opcode 111 with any header other than 0xFF are ignored. MISO stays 0x00 for the whole window and no register, bank or pointer changes.
- R10: The single byte 0xFF clears every register, including 0x1F (so the bank becomes 0), and the pointer. Buffer contents are kept.
- R11: After rst_ni is asserted, all registers, the buffer, the bank and the pointer are 0 and MISO is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the SPI pins |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | SPI serial clock |
| cs_ni | input | 1 | SPI chip select, active low |
| mosi_i | input | 1 | Serial data in |
| miso_o | output | 1 | Serial data out |

## Verification
SCK, CS_n and MOSI pass through two synchronizer flops and one edge-detect flop. A byte is therefore complete about three system clocks after its eighth SCK rise, and the reply byte is loaded in that same cycle. Its MSB then stays on MISO through the next falling edge. Each later bit appears about three clocks after its SCK fall. The bench holds each SCK phase for six system clocks and samples MISO just before it raises SCK, so every bit is read at least two clocks after it is due. Register, bank and pointer updates take effect one clock after byte completion, well before the next byte. The bench checks them by reading back in later windows, comparing against a model that it updates only from the commands it sends.

// File: rtl/spi_bank_pkg.sv
`timescale 1ns/1ps
package spi_bank_pkg;
  typedef enum logic [2:0] {
    OP_RD_REG   = 3'b000,
    OP_RD_BUF   = 3'b001,
    OP_WR_REG   = 3'b010,
    OP_WR_BUF   = 3'b011,
    OP_BIT_SET  = 3'b100,
    OP_BIT_CLR  = 3'b101,
    OP_RSVD     = 3'b110,
    OP_SOFT_RST = 3'b111
  } opcode_e;

  typedef enum logic [2:0] {
    M_NONE, M_RD_REG, M_RD_BUF, M_WR_REG, M_WR_BUF
  } mode_e;

  typedef enum logic [1:0] {WM_WRITE, WM_SET, WM_CLR} wmode_e;

  localparam logic [7:0] HDR_RD_BUF   = 8'h3A;
  localparam logic [7:0] HDR_WR_BUF   = 8'h7A;
  localparam logic [7:0] HDR_SOFT_RST = 8'hFF;
endpackage

// File: rtl/spi_bank_sync.sv
`timescale 1ns/1ps
module spi_bank_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic cs_ni,
  input  logic mosi_i,
  output logic sck_rise_o,
  output logic sck_fall_o,
  output logic sel_o,
  output logic mosi_o
);
  logic [STAGES-1:0] sck_sr, cs_sr, mosi_sr;
  logic sck_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_sr  <= '0;
      cs_sr   <= '1;
      mosi_sr <= '0;
      sck_d   <= 1'b0;
    end else begin
      sck_sr  <= {sck_sr[STAGES-2:0], sck_i};
      cs_sr   <= {cs_sr[STAGES-2:0], cs_ni};
      mosi_sr <= {mosi_sr[STAGES-2:0], mosi_i};
      sck_d   <= sck_sr[STAGES-1];
    end
  end

  assign sck_rise_o = sck_sr[STAGES-1] & ~sck_d;
  assign sck_fall_o = ~sck_sr[STAGES-1] & sck_d;
  assign sel_o      = ~cs_sr[STAGES-1];
  assign mosi_o     = mosi_sr[STAGES-1];
endmodule

// File: rtl/spi_bank_shifter.sv
`timescale 1ns/1ps
module spi_bank_shifter #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sel_i,
  input  logic         rise_i,
  input  logic         fall_i,
  input  logic         mosi_i,
  input  logic [W-1:0] tx_byte_i,
  output logic         done_o,
  output logic [W-1:0] rx_byte_o,
  output logic         miso_o
);
  localparam int CW = $clog2(W);

  logic [W-1:0]  rx_q, tx_q;
  logic [CW-1:0] cnt_q;
  logic          hold_q;  // skip the fall right after a reply load

  assign rx_byte_o = {rx_q[W-2:0], mosi_i};
  assign done_o    = sel_i & rise_i & (cnt_q == CW'(W-1));
  assign miso_o    = tx_q[W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_q <= '0; tx_q <= '0; cnt_q <= '0; hold_q <= 1'b0;
    end else if (!sel_i) begin
      rx_q <= '0; tx_q <= '0; cnt_q <= '0; hold_q <= 1'b0;
    end else if (rise_i) begin
      rx_q  <= rx_byte_o;
      cnt_q <= done_o ? '0 : cnt_q + 1'b1;
      if (done_o) begin
        tx_q   <= tx_byte_i;
        hold_q <= 1'b1;
      end
    end else if (fall_i) begin
      if (hold_q) hold_q <= 1'b0;
      else        tx_q   <= {tx_q[W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/spi_bank_regfile.sv
`timescale 1ns/1ps
module spi_bank_regfile
  import spi_bank_pkg::*;
#(
  parameter int NBANK = 4,
  parameter int AW    = 5,
  parameter int DW    = 8,
  localparam int BW   = $clog2(NBANK)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          we_i,
  input  wmode_e        wmode_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic [BW-1:0] bank_o
);
  localparam int NREG = 2**AW;

  function automatic logic [DW-1:0] merge(logic [DW-1:0] old, logic [DW-1:0] d, wmode_e m);
    case (m)
      WM_SET:  return old | d;
      WM_CLR:  return old & ~d;
      default: return d;
    endcase
  endfunction

  logic [DW-1:0] ctl_q;
  logic          is_ctl;
  logic [NBANK-1:0][DW-1:0] bank_rd;

  assign is_ctl = (addr_i == {AW{1'b1}});
  assign bank_o = ctl_q[BW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 ctl_q <= '0;
    else if (clr_i)              ctl_q <= '0;
    else if (we_i && is_ctl)     ctl_q <= merge(ctl_q, wdata_i, wmode_i);
  end

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    logic [DW-1:0] regs_q [NREG];
    logic          hit;
    assign hit = we_i && !is_ctl && (bank_o == BW'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int r = 0; r < NREG; r++) regs_q[r] <= '0;
      end else if (clr_i) begin
        for (int r = 0; r < NREG; r++) regs_q[r] <= '0;
      end else if (hit) begin
        regs_q[addr_i] <= merge(regs_q[addr_i], wdata_i, wmode_i);
      end
    end
    assign bank_rd[g] = regs_q[addr_i];
  end

  assign rdata_o = is_ctl ? ctl_q : bank_rd[bank_o];
endmodule

// File: rtl/spi_bank_bufmem.sv
`timescale 1ns/1ps
module spi_bank_bufmem #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_ptr_i,
  input  logic          we_i,
  input  logic          adv_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rd_cur_o,
  output logic [DW-1:0] rd_nxt_o,
  output logic [PW-1:0] ptr_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] ptr_q, ptr_nxt;

  assign ptr_nxt  = (ptr_q == PW'(DEPTH-1)) ? '0 : ptr_q + 1'b1;
  assign rd_cur_o = mem_q[ptr_q];
  assign rd_nxt_o = mem_q[ptr_nxt];
  assign ptr_o    = ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (we_i) mem_q[ptr_q] <= wdata_i;
      if (clr_ptr_i)  ptr_q <= '0;
      else if (adv_i) ptr_q <= ptr_nxt;
    end
  end
endmodule

// File: rtl/spi_bank_engine.sv
`timescale 1ns/1ps
module spi_bank_engine
  import spi_bank_pkg::*;
#(
  parameter int NBANK        = 4,
  parameter int BUF_DEPTH    = 64,
  parameter int DLY_BANK_MIN = 2,
  parameter int DLY_ADDR_LIM = 16,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic cs_ni,
  input  logic mosi_i,
  output logic miso_o
);
  localparam int DW     = 8;
  localparam int AW     = 5;
  localparam int BANK_W = $clog2(NBANK);
  localparam int PTR_W  = $clog2(BUF_DEPTH);
  localparam logic [BANK_W-1:0] DLY_BANK = BANK_W'(DLY_BANK_MIN);
  localparam logic [AW-1:0]     DLY_LIM  = AW'(DLY_ADDR_LIM);

  logic sck_rise, sck_fall, sel, mosi_s;
  logic byte_done;
  logic [DW-1:0] rx_byte, tx_next;
  logic [DW-1:0] rf_rdata, buf_cur, buf_nxt;
  logic [BANK_W-1:0] bank;
  logic [PTR_W-1:0]  ptr;
  logic rf_we, buf_we, buf_adv, soft_clr, dly_class;
  logic [AW-1:0] rf_addr;

  logic [1:0]    idx_q;
  mode_e         mode_q, mode_d;
  wmode_e        wm_q, wm_d;
  logic          dly_q, dly_d;
  logic [AW-1:0] addr_q;
  opcode_e       op;

  spi_bank_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .sck_i, .cs_ni, .mosi_i,
    .sck_rise_o(sck_rise), .sck_fall_o(sck_fall), .sel_o(sel), .mosi_o(mosi_s)
  );

  spi_bank_shifter #(.W(DW)) u_shift (
    .clk_i, .rst_ni, .sel_i(sel), .rise_i(sck_rise), .fall_i(sck_fall),
    .mosi_i(mosi_s), .tx_byte_i(tx_next), .done_o(byte_done),
    .rx_byte_o(rx_byte), .miso_o
  );

  spi_bank_regfile #(.NBANK(NBANK), .AW(AW), .DW(DW)) u_rf (
    .clk_i, .rst_ni, .clr_i(soft_clr), .we_i(rf_we), .wmode_i(wm_q),
    .addr_i(rf_addr), .wdata_i(rx_byte), .rdata_o(rf_rdata), .bank_o(bank)
  );

  spi_bank_bufmem #(.DEPTH(BUF_DEPTH), .DW(DW)) u_buf (
    .clk_i, .rst_ni, .clr_ptr_i(soft_clr), .we_i(buf_we), .adv_i(buf_adv),
    .wdata_i(rx_byte), .rd_cur_o(buf_cur), .rd_nxt_o(buf_nxt), .ptr_o(ptr)
  );

  assign op        = opcode_e'(rx_byte[7:5]);
  assign rf_addr   = (idx_q == 2'd0) ? rx_byte[AW-1:0] : addr_q;
  assign dly_class = (bank >= DLY_BANK) && (rx_byte[AW-1:0] < DLY_LIM);

  always_comb begin
    tx_next  = '0;
    rf_we    = 1'b0;
    buf_we   = 1'b0;
    buf_adv  = 1'b0;
    soft_clr = 1'b0;
    mode_d   = mode_q;
    wm_d     = wm_q;
    dly_d    = dly_q;
    if (byte_done) begin
      if (idx_q == 2'd0) begin
        mode_d = M_NONE;
        case (op)
          OP_RD_REG: begin
            mode_d  = M_RD_REG;
            dly_d   = dly_class;
            tx_next = dly_class ? '0 : rf_rdata;
          end
          OP_RD_BUF: if (rx_byte == HDR_RD_BUF) begin
            mode_d  = M_RD_BUF;
            tx_next = buf_cur;
          end
          OP_WR_BUF: if (rx_byte == HDR_WR_BUF) mode_d = M_WR_BUF;
          OP_WR_REG:  begin mode_d = M_WR_REG; wm_d = WM_WRITE; end
          OP_BIT_SET: begin mode_d = M_WR_REG; wm_d = WM_SET;   end
          OP_BIT_CLR: begin mode_d = M_WR_REG; wm_d = WM_CLR;   end
          OP_SOFT_RST: soft_clr = (rx_byte == HDR_SOFT_RST);
          default: ;
        endcase
      end else begin
        case (mode_q)
          M_RD_REG: if (idx_q == 2'd1 && dly_q) tx_next = rf_rdata;
          M_WR_REG: rf_we = (idx_q == 2'd1);
          M_RD_BUF: begin buf_adv = 1'b1; tx_next = buf_nxt; end
          M_WR_BUF: begin buf_we = 1'b1; buf_adv = 1'b1; end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0; mode_q <= M_NONE; wm_q <= WM_WRITE; dly_q <= 1'b0; addr_q <= '0;
    end else if (!sel) begin
      idx_q <= '0; mode_q <= M_NONE;
    end else if (byte_done) begin
      idx_q  <= (idx_q == 2'd2) ? idx_q : idx_q + 1'b1;
      mode_q <= mode_d;
      wm_q   <= wm_d;
      dly_q  <= dly_d;
      if (idx_q == 2'd0) addr_q <= rx_byte[AW-1:0];
    end
  end
endmodule

// File: rtl/spi_bank_engine_chk.sv
`timescale 1ns/1ps
module spi_bank_engine_chk #(
  parameter int BW = 2,
  parameter int PW = 6
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          sel_i,
  input logic          byte_done_i,
  input logic          soft_clr_i,
  input logic          miso_i,
  input logic [BW-1:0] bank_i,
  input logic [PW-1:0] ptr_i
);
  assert_miso_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_i |=> !miso_i);

  assert_done_pulse_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_done_i |=> !byte_done_i);

  assert_bank_on_byte_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bank_i != $past(bank_i)) |-> $past(byte_done_i));

  assert_ptr_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr_i != $past(ptr_i)) |-> (ptr_i == PW'($past(ptr_i) + 1'b1) || ptr_i == '0));

  assert_ptr_on_byte_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr_i != $past(ptr_i)) |-> $past(byte_done_i));

  assert_soft_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_clr_i |=> (bank_i == '0 && ptr_i == '0));
endmodule

bind spi_bank_engine spi_bank_engine_chk #(.BW(BANK_W), .PW(PTR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel), .byte_done_i(byte_done),
  .soft_clr_i(soft_clr), .miso_i(miso_o), .bank_i(bank), .ptr_i(ptr)
);

// File: tb/sim_spi_bank_engine.sv
`timescale 1ns/1ps
module sim_spi_bank_engine;
  localparam int HALF = 6;

  logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso;

  always #2.5 clk = ~clk;

  spi_bank_engine u0 (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .cs_ni(cs_n), .mosi_i(mosi), .miso_o(miso)
  );

  logic [7:0] m_reg [4][32];
  logic [7:0] m_ctl;
  logic [7:0] m_buf [64];
  int         m_ptr;
  logic [7:0] txb [80];
  logic [7:0] rxb [80];
  int n_cmp = 0, n_bad = 0;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual %02h expected %02h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] cur_bank();
    return m_ctl[1:0];
  endfunction

  function automatic logic is_dly(input logic [4:0] a);
    return (cur_bank() >= 2'd2) && (a < 5'd16);
  endfunction

  function automatic logic [7:0] reg_val(input logic [4:0] a);
    return (a == 5'h1F) ? m_ctl : m_reg[cur_bank()][a];
  endfunction

  task automatic xfer(input int n);
    @(negedge clk); cs_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      for (int b = 7; b >= 0; b--) begin
        mosi = txb[i][b];
        repeat (HALF) @(negedge clk);
        rxb[i][b] = miso;
        sck = 1'b1;
        repeat (HALF) @(negedge clk);
        sck = 1'b0;
      end
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic do_rd_reg(input logic [4:0] a, input string req);
    logic d = is_dly(a);
    logic [7:0] v = reg_val(a);
    txb[0] = {3'b000, a};
    for (int k = 1; k < 4; k++) txb[k] = 8'($urandom);
    xfer(4);
    chk("R1", rxb[0], 8'h00);
    if (d) begin
      chk(req, rxb[1], 8'h00); chk(req, rxb[2], v); chk(req, rxb[3], 8'h00);
    end else begin
      chk(req, rxb[1], v); chk(req, rxb[2], 8'h00); chk(req, rxb[3], 8'h00);
    end
  endtask

  task automatic do_wr(input logic [2:0] op, input logic [4:0] a, input logic [7:0] d, input int extra);
    logic [7:0] old = reg_val(a);
    logic [7:0] nv;
    txb[0] = {op, a};
    txb[1] = d;
    for (int k = 2; k < 2 + extra; k++) txb[k] = 8'($urandom);
    xfer(2 + extra);
    nv = (op == 3'b010) ? d : (op == 3'b100) ? (old | d) : (old & ~d);
    if (a == 5'h1F) m_ctl = nv;
    else m_reg[cur_bank()][a] = nv;
  endtask

  task automatic do_wbuf(input int n);
    txb[0] = 8'h7A;
    for (int k = 1; k <= n; k++) txb[k] = 8'($urandom);
    xfer(n + 1);
    for (int k = 1; k <= n; k++) begin
      m_buf[m_ptr] = txb[k];
      m_ptr = (m_ptr + 1) % 64;
    end
  endtask

  task automatic do_rbuf(input int n, input string req);
    txb[0] = 8'h3A;
    for (int k = 1; k <= n; k++) txb[k] = 8'($urandom);
    xfer(n + 1);
    chk("R1", rxb[0], 8'h00);
    for (int k = 1; k <= n; k++) begin
      chk(req, rxb[k], m_buf[m_ptr]);
      m_ptr = (m_ptr + 1) % 64;
    end
  endtask

  task automatic do_junk(input logic [7:0] hdr, input int n);
    txb[0] = hdr;
    for (int k = 1; k < n; k++) txb[k] = 8'($urandom);
    xfer(n);
    for (int k = 0; k < n; k++) chk("R9", rxb[k], 8'h00);
  endtask

  function automatic logic [7:0] junk_hdr(input int sel, input logic [4:0] a);
    case (sel)
      0: return {3'b110, a};
      1: return {3'b001, (a == 5'h1A) ? 5'h1B : a};
      2: return {3'b011, (a == 5'h1A) ? 5'h00 : a};
      default: return {3'b111, (a == 5'h1F) ? 5'h0E : a};
    endcase
  endfunction

  task automatic do_soft();
    txb[0] = 8'hFF;
    xfer(1);
    m_ctl = '0;
    m_ptr = 0;
    for (int b = 0; b < 4; b++) for (int r = 0; r < 32; r++) m_reg[b][r] = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20517));
    m_ctl = '0; m_ptr = 0;
    for (int b = 0; b < 4; b++) for (int r = 0; r < 32; r++) m_reg[b][r] = '0;
    for (int i = 0; i < 64; i++) m_buf[i] = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // reset state
    chk("R11", {7'd0, miso}, 8'h00);
    do_rd_reg(5'h1F, "R11");
    do_rd_reg(5'h05, "R11");
    do_rbuf(2, "R11");

    // plain write/read in bank 0
    do_wr(3'b010, 5'h05, 8'hA5, 0);
    do_rd_reg(5'h05, "R2");
    do_rd_reg(5'h05, "R3");

    // bank 2: slow-path and ordinary registers
    do_wr(3'b010, 5'h1F, 8'h02, 0);
    do_rd_reg(5'h1F, "R6");
    do_wr(3'b010, 5'h03, 8'h3C, 0);
    do_rd_reg(5'h03, "R4");
    do_wr(3'b010, 5'h14, 8'h5A, 0);
    do_rd_reg(5'h14, "R3");
    do_rd_reg(5'h05, "R6");

    // bank bits via set/clear on the common register
    do_wr(3'b100, 5'h1F, 8'h01, 0);
    do_wr(3'b010, 5'h05, 8'h77, 0);
    do_rd_reg(5'h05, "R4");
    do_wr(3'b101, 5'h1F, 8'h02, 0);
    do_rd_reg(5'h1F, "R6");
    do_rd_reg(5'h05, "R6");
    do_wr(3'b010, 5'h09, 8'h0F, 0);
    do_wr(3'b100, 5'h09, 8'hF0, 0);
    do_rd_reg(5'h09, "R5");
    do_wr(3'b101, 5'h09, 8'h3C, 0);
    do_rd_reg(5'h09, "R5");

    // trailing bytes after a write are ignored
    do_wr(3'b010, 5'h07, 8'h11, 3);
    do_rd_reg(5'h07, "R2");

    // buffer stream across the wrap
    do_wbuf(70);
    do_rbuf(10, "R8");
    do_rbuf(60, "R7");

    // ignored headers leave everything intact
    for (int s = 0; s < 4; s++) do_junk(junk_hdr(s, 5'h1A), 3);
    do_junk(8'hC9, 2);
    do_rd_reg(5'h09, "R9");
    do_rd_reg(5'h1F, "R9");
    do_rbuf(2, "R9");

    // soft reset keeps buffer, clears registers and pointer
    do_wr(3'b010, 5'h1F, 8'h03, 0);
    do_wr(3'b010, 5'h02, 8'h99, 0);
    do_soft();
    do_rd_reg(5'h1F, "R10");
    do_rd_reg(5'h02, "R10");
    do_wr(3'b010, 5'h1F, 8'h03, 0);
    do_rd_reg(5'h02, "R10");
    do_rbuf(3, "R10");

    // constrained random mix
    for (int it = 0; it < 110; it++) begin
      int sel = $urandom_range(0, 9);
      logic [4:0] a = 5'($urandom);
      logic [7:0] d = 8'($urandom);
      case (sel)
        0, 1: do_rd_reg(a, is_dly(a) ? "R4" : "R3");
        2:    do_wr(3'b010, a, d, $urandom_range(0, 1));
        3:    do_wr(3'b100, a, d, 0);
        4:    do_wr(3'b101, a, d, 0);
        5:    do_wbuf($urandom_range(1, 5));
        6:    do_rbuf($urandom_range(1, 5), "R8");
        7:    do_junk(junk_hdr($urandom_range(0, 3), a), 2);
        8:    do_wr(3'b010, 5'h1F, d, 0);
        default: if (it % 3 == 0) do_soft(); else do_rd_reg(5'h1F, "R6");
      endcase
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule